// File: doc/BRIEF.md
# Edge Interrupt Capture-and-Replay Controller

This block is a second-level interrupt stage placed between a set of external interrupt lines and a main interrupt controller that can lose power. While it is off, every line passes straight through to the parent. Before the parent is powered down, software enables the block in edge-recording mode. From then on, every qualifying edge on an unmasked, edge-sensitive line is held in a per-line pending bit. After the parent is powered again, software writes the flush command. Each pending line is then replayed to the parent as a single-cycle pulse, so no edge interrupt is lost across the power-down.

Each line has a mask bit, a sensitivity bit and a polarity bit. Software sets these bits and clears them through separate write-one-to-set and write-one-to-clear addresses on a small APB-style register bus. Pending bits are cleared by writing ones to an acknowledge array. Thirty-two lines share one 32-bit word. The number of lines is a parameter.

Top module: `edge_replay_ctrl`

## Requirements
- R1: After reset, every line is masked (mask bit 1), edge-sensitive (sensitivity bit 0) and rising-polarity (polarity bit 1), the control word reads 0 and no line is pending.
- R2: Word k of an array at byte offset base+4k covers lines 32k..32k+31, with line i at bit i mod 32. The bases are: acknowledge 0x40, mask set 0xC0, mask clear 0x100, sensitivity set 0x180, sensitivity clear 0x1C0, polarity set 0x240, polarity clear 0x280. Control is at 0x300. A write to a set address forces the bits written as 1 to 1, and a write to a clear address forces them to 0. All other bits keep their value. Reads of either address of a pair return the current configuration word.
- R3: With control bit 0 (enable) at 0, each output line equals its input line in the same cycle and nothing is recorded.
- R4: With enable and control bit 1 (edge recording) both 1, a line with mask 0 and sensitivity 0 records a rising edge when its polarity is 1, or a falling edge when its polarity is 0, into its pending bit. The pending bit reads back at the acknowledge address on the cycle after the edge.
- R5: A masked line, or a line with sensitivity 1 (level mode), never records.
- R6: With enable 1 and edge recording 0, nothing is recorded. While enable is 1, outputs are 0 except for replay pulses.
- R7: Writing control with bit 2 (flush) at 1 pulses every pending line on its output for exactly the one cycle after the write, and clears those pending bits. Lines that are not pending stay 0. Control bit 2 always reads 0.
- R8: Writing 1 to an acknowledge bit clears that pending bit. Writing 0 to an acknowledge bit leaves it unchanged.
- R9: An edge that is recorded in the replay cycle itself stays pending for the next flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; only word-aligned accesses take effect |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_in | input | NUM_LINES | External interrupt lines |
| irq_out | output | NUM_LINES | Lines to the parent controller |

## Verification
A wrong pending bit has two visible effects. It shows on the acknowledge read on the cycle after the edge, and on the next flush it appears as a missing or extra pulse in the single replay cycle. A stuck flush strobe or a wrong output gating shows on `irq_out` in the very cycle it goes wrong. The outputs are compared against a reference model on every cycle, so such faults are seen at once. A wrong mask, sensitivity or polarity bit shows on the next read of its set or clear word. It also shows as an edge that is recorded or dropped wrongly during the random phases.

// File: rtl/erc_pkg.sv
// Shared constants for the edge capture-and-replay controller.
// Assumes 64-byte register regions selected by address bits [11:6].
package erc_pkg;
    localparam int WORD_W = 32;
    typedef enum logic [5:0] {
        RG_ACK  = 6'd1,
        RG_MSET = 6'd3,
        RG_MCLR = 6'd4,
        RG_SSET = 6'd6,
        RG_SCLR = 6'd7,
        RG_PSET = 6'd9,
        RG_PCLR = 6'd10,
        RG_CTRL = 6'd12
    } region_e;
    localparam int CTRL_EN    = 0;
    localparam int CTRL_EDGE  = 1;
    localparam int CTRL_FLUSH = 2;
endpackage

// File: rtl/erc_regfile.sv
// Register file: per-line set/clear configuration arrays, control word,
// acknowledge strobes and read mux. Assumes NUM_LINES <= 512 (16 words
// per region) and APB-style two-phase accesses.
module erc_regfile
    import erc_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [11:0]          paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_LINES-1:0] pend_i,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sens_o,
    output logic [NUM_LINES-1:0] pol_o,
    output logic [NUM_LINES-1:0] ack_o,
    output logic                 en_o,
    output logic                 edg_o,
    output logic                 flush_o
);
    localparam int NW = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int NP = NW * WORD_W;

    logic [5:0]     region;
    logic [3:0]     widx;
    logic           wr;
    logic [NP-1:0]  wbits;
    logic [NUM_LINES-1:0] mset, mclr, sset, sclr, pset, pclr;
    logic [NP-1:0]  mask_p, sens_p, pol_p, pend_p;

    assign region = paddr[11:6];
    assign widx   = paddr[5:2];
    assign wr     = psel && penable && pwrite && (paddr[1:0] == 2'b00);

    // Place the write data into the addressed word of a full-width vector.
    for (genvar w = 0; w < NW; w++) begin : g_word
        assign wbits[w*WORD_W +: WORD_W] = (widx == 4'(w)) ? pwdata : '0;
    end

    // Per-array write strobes.
    assign mset  = (wr && region == RG_MSET) ? wbits[NUM_LINES-1:0] : '0;
    assign mclr  = (wr && region == RG_MCLR) ? wbits[NUM_LINES-1:0] : '0;
    assign sset  = (wr && region == RG_SSET) ? wbits[NUM_LINES-1:0] : '0;
    assign sclr  = (wr && region == RG_SCLR) ? wbits[NUM_LINES-1:0] : '0;
    assign pset  = (wr && region == RG_PSET) ? wbits[NUM_LINES-1:0] : '0;
    assign pclr  = (wr && region == RG_PCLR) ? wbits[NUM_LINES-1:0] : '0;
    assign ack_o = (wr && region == RG_ACK)  ? wbits[NUM_LINES-1:0] : '0;

    // Configuration arrays: set forces ones, clear forces zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '1;
            sens_o <= '0;
            pol_o  <= '1;
        end else begin
            mask_o <= (mask_o | mset) & ~mclr;
            sens_o <= (sens_o | sset) & ~sclr;
            pol_o  <= (pol_o  | pset) & ~pclr;
        end
    end

    // Control word; the flush bit is a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            edg_o   <= 1'b0;
            flush_o <= 1'b0;
        end else if (wr && region == RG_CTRL && widx == 4'd0) begin
            en_o    <= pwdata[CTRL_EN];
            edg_o   <= pwdata[CTRL_EDGE];
            flush_o <= pwdata[CTRL_FLUSH];
        end else begin
            flush_o <= 1'b0;
        end
    end

    // Zero-pad arrays to whole words for the read mux.
    always_comb begin
        mask_p = '0; sens_p = '0; pol_p = '0; pend_p = '0;
        mask_p[NUM_LINES-1:0] = mask_o;
        sens_p[NUM_LINES-1:0] = sens_o;
        pol_p[NUM_LINES-1:0]  = pol_o;
        pend_p[NUM_LINES-1:0] = pend_i;
    end

    function automatic logic [31:0] pick(input logic [NP-1:0] v, input logic [3:0] i);
        logic [31:0] r;
        r = '0;
        for (int w = 0; w < NW; w++) begin
            if (i == 4'(w)) r = v[w*WORD_W +: WORD_W];
        end
        return r;
    endfunction

    // Read mux: both addresses of a pair return the same array.
    always_comb begin
        case (region)
            RG_ACK:           prdata = pick(pend_p, widx);
            RG_MSET, RG_MCLR: prdata = pick(mask_p, widx);
            RG_SSET, RG_SCLR: prdata = pick(sens_p, widx);
            RG_PSET, RG_PCLR: prdata = pick(pol_p, widx);
            RG_CTRL:          prdata = (widx == 4'd0) ? {29'd0, 1'b0, edg_o, en_o} : '0;
            default:          prdata = '0;
        endcase
    end

    // R7: the flush strobe never lasts beyond one cycle.
    assert_flush_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R2: bits written to the mask clear address read back as 0.
    assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_MCLR) |=> ((mask_o & $past(mclr)) == '0));
endmodule

// File: rtl/erc_edge_det.sv
// Edge detector: registers the previous input level and flags an edge of
// the configured polarity per line (polarity 1 = rising, 0 = falling).
// Assumes inputs are already synchronous to clk.
module erc_edge_det #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] in_i,
    input  logic [NUM_LINES-1:0] pol_i,
    output logic [NUM_LINES-1:0] hit_o
);
    logic [NUM_LINES-1:0] prev_q;

    // Previous-cycle input level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= in_i;
    end

    assign hit_o = (pol_i & in_i & ~prev_q) | (~pol_i & ~in_i & prev_q);
endmodule

// File: rtl/erc_pending.sv
// Pending storage and replay: records qualified edges, drives a one-cycle
// replay vector on flush, and clears replayed or acknowledged bits. An edge
// recorded in the same cycle as a clear wins, so it is kept.
module erc_pending #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rec_en_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] sens_i,
    input  logic [NUM_LINES-1:0] hit_i,
    input  logic                 flush_i,
    input  logic [NUM_LINES-1:0] ack_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] replay_o
);
    logic [NUM_LINES-1:0] rec;

    assign rec      = {NUM_LINES{rec_en_i}} & ~mask_i & ~sens_i & hit_i;
    assign replay_o = flush_i ? pend_o : '0;

    // Pending bits: clear on ack or replay, set on a recorded edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~(ack_i | replay_o)) | rec;
    end

    // R5: a newly pending bit was unmasked and edge-sensitive.
    assert_masked_no_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ($past(mask_i) | $past(sens_i))) == '0));

    // R6: nothing becomes pending while recording is off.
    assert_no_record_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en_i |=> ((pend_o & ~$past(pend_o)) == '0));

    // R7: after a flush only re-hit lines remain pending.
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> ((pend_o & ~$past(hit_i)) == '0));

    // R8: acknowledged bits clear unless re-hit.
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i != '0) |=> ((pend_o & $past(ack_i) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/edge_replay_ctrl.sv
// Top: edge capture-and-replay interrupt controller. Passes lines through
// while disabled; while enabled, outputs only replay pulses.
// Assumes synchronous inputs and a register bus in the same clock domain.
module edge_replay_ctrl #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [11:0]          paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] mask, sens, pol, ack, hit, pend, replay;
    logic en, edg, flush;

    erc_regfile #(.NUM_LINES(NUM_LINES)) regs_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pend_i(pend), .mask_o(mask), .sens_o(sens), .pol_o(pol),
        .ack_o(ack), .en_o(en), .edg_o(edg), .flush_o(flush)
    );

    erc_edge_det #(.NUM_LINES(NUM_LINES)) edet_i (
        .clk(clk), .rst_n(rst_n), .in_i(irq_in), .pol_i(pol), .hit_o(hit)
    );

    erc_pending #(.NUM_LINES(NUM_LINES)) pend_i (
        .clk(clk), .rst_n(rst_n), .rec_en_i(en && edg), .mask_i(mask),
        .sens_i(sens), .hit_i(hit), .flush_i(flush), .ack_i(ack),
        .pend_o(pend), .replay_o(replay)
    );

    // Output: pass-through when disabled, plus replay pulses.
    assign irq_out = (en ? '0 : irq_in) | replay;

    // R6: while enabled, any active output is a pending line being replayed.
    assert_enabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((irq_out & ~pend) == '0));
endmodule

// File: tb/edge_replay_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_replay_ctrl_tb_top;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] irq_out;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Reference model state
    logic [N-1:0] m_mask, m_sens, m_pol, m_pend, m_prev, cur_in;
    logic m_en, m_edge, m_flush;
    logic [31:0] rd_val;

    edge_replay_ctrl #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [N-1:0] v, input logic [3:0] wi);
        return (wi < 4'd2) ? v[wi*32 +: 32] : 32'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [3:0] wi;
        wi = a[5:2];
        case (a[11:6])
            6'd1:       return word_of(m_pend, wi);
            6'd3, 6'd4: return word_of(m_mask, wi);
            6'd6, 6'd7: return word_of(m_sens, wi);
            6'd9, 6'd10: return word_of(m_pol, wi);
            6'd12:      return (wi == 0) ? {30'd0, m_edge, m_en} : 32'd0;
            default:    return 32'd0;
        endcase
    endfunction

    // One clock cycle: drive at negedge, check outputs, advance model.
    task automatic drive_cycle(input logic s, input logic e, input logic w,
                               input logic [11:0] a, input logic [31:0] d);
        logic [N-1:0] exp_out, wb, rec, clr, hit;
        logic nf;
        @(negedge clk);
        psel = s; penable = e; pwrite = w; paddr = a; pwdata = d; irq_in = cur_in;
        #1;
        rd_val = prdata;
        exp_out = (m_en ? '0 : cur_in) | (m_flush ? m_pend : '0);
        chk(irq_out == exp_out, m_flush ? "R7 replay" : (m_en ? "R6 quiet" : "R3 pass"),
            irq_out, exp_out);
        hit = (m_pol & cur_in & ~m_prev) | (~m_pol & ~cur_in & m_prev);
        rec = (m_en && m_edge) ? (~m_mask & ~m_sens & hit) : '0;
        clr = m_flush ? m_pend : '0;
        nf = 1'b0;
        wb = (a[5:2] < 4'd2) ? (64'(d) << (32 * a[5:2])) : '0;
        @(posedge clk);
        if (s && e && w && a[1:0] == 2'b00) begin
            case (a[11:6])
                6'd1:  clr = clr | wb;
                6'd3:  m_mask = m_mask | wb;
                6'd4:  m_mask = m_mask & ~wb;
                6'd6:  m_sens = m_sens | wb;
                6'd7:  m_sens = m_sens & ~wb;
                6'd9:  m_pol = m_pol | wb;
                6'd10: m_pol = m_pol & ~wb;
                6'd12: if (a[5:2] == 0) begin m_en = d[0]; m_edge = d[1]; nf = d[2]; end
                default: ;
            endcase
        end
        m_pend = (m_pend & ~clr) | rec;
        m_flush = nf;
        m_prev = cur_in;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        drive_cycle(1'b1, 1'b0, 1'b1, a, d);
        drive_cycle(1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        e = exp_read(a);
        drive_cycle(1'b1, 1'b1, 1'b0, a, 32'd0);
        chk(rd_val == e, tag, 64'(rd_val), 64'(e));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_cycle(1'b0, 1'b0, 1'b0, 12'h0, 32'd0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5717));
        m_mask = '1; m_sens = '0; m_pol = '1; m_pend = '0; m_prev = '0;
        m_en = 0; m_edge = 0; m_flush = 0; cur_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(12'h0C0, "R1 mask w0"); rd(12'h104, "R1 mask w1");
        rd(12'h180, "R1 sens w0"); rd(12'h244, "R1 pol w1");
        rd(12'h300, "R1 ctrl"); rd(12'h040, "R1 pend w0");
        chk(m_mask == '1 && rd_val == 0, "R1 const", 64'(rd_val), 64'd0);

        // R2 set/clear semantics and word mapping (line 40 = word 1 bit 8)
        wr(12'h100, 32'h0000_00F0); rd(12'h0C0, "R2 mask clr");
        chk(rd_val == 32'hFFFF_FF0F, "R2 mask clr value", 64'(rd_val), 64'hFFFF_FF0F);
        wr(12'h0C0, 32'h0000_0010); rd(12'h100, "R2 mask set");
        wr(12'h184, 32'h0000_0100); rd(12'h1C4, "R2 sens line40");
        chk(rd_val == 32'h100, "R2 line40 bit", 64'(rd_val), 64'h100);
        wr(12'h1C4, 32'h0000_0100); rd(12'h184, "R2 sens clr");

        // R3 pass-through while disabled; unmask everything, toggle lines
        wr(12'h100, 32'hFFFF_FFFF); wr(12'h104, 32'hFFFF_FFFF);
        cur_in = 64'hA5A5_0000_FFFF_1234; idle(2);
        cur_in = 64'h0; idle(2);
        rd(12'h040, "R3 no record"); rd(12'h044, "R3 no record w1");

        // R4 recording: line0 rising, line1 falling (pol clear bit1)
        wr(12'h280, 32'h2);
        cur_in = 64'h2; idle(1);
        wr(12'h300, 32'h3);
        cur_in = 64'h1; idle(1);
        rd(12'h040, "R4 pend");
        chk(rd_val[1:0] == 2'b11, "R4 pend bits", 64'(rd_val), 64'h3);

        // R5 masked line2, level line3
        wr(12'h0C0, 32'h4); wr(12'h180, 32'h8);
        cur_in = 64'hD; idle(1); cur_in = 64'h1; idle(1); cur_in = 64'hD; idle(1);
        rd(12'h040, "R5 no record");
        chk(rd_val[3:2] == 2'b00, "R5 bits", 64'(rd_val), 64'h3);

        // R8 acknowledge bit0 only
        wr(12'h040, 32'h1); rd(12'h040, "R8 ack");
        chk(rd_val[1:0] == 2'b10, "R8 bits", 64'(rd_val), 64'h2);

        // R7 flush, then R9 edge during the replay cycle (line 4 rising)
        cur_in = 64'h0; idle(1);
        wr(12'h300, 32'h7);
        cur_in = 64'h10; idle(1);
        rd(12'h300, "R7 flush reads 0");
        rd(12'h040, "R9 kept");
        chk(rd_val[4] == 1'b1 && rd_val[1] == 1'b0, "R9 bit4", 64'(rd_val), 64'h10);
        wr(12'h300, 32'h7); idle(2);
        rd(12'h040, "R7 cleared");

        // R6 enabled without edge recording
        wr(12'h300, 32'h1);
        cur_in = 64'hFFFF; idle(2); cur_in = 64'h0; idle(2);
        rd(12'h040, "R6 no record");

        // Random phases
        for (int r = 0; r < 6; r++) begin
            wr(12'h300, 32'h0);
            for (int k = 0; k < 2; k++) begin
                wr(12'h0C0 + 12'(4*k), $urandom); wr(12'h100 + 12'(4*k), $urandom);
                wr(12'h180 + 12'(4*k), $urandom); wr(12'h1C0 + 12'(4*k), $urandom);
                wr(12'h240 + 12'(4*k), $urandom); wr(12'h280 + 12'(4*k), $urandom);
            end
            rd(12'h0C0, "R2 rand mask"); rd(12'h1C4, "R2 rand sens");
            rd(12'h280, "R2 rand pol");
            wr(12'h300, 32'h3);
            for (int c = 0; c < 120; c++) begin
                cur_in = {$urandom, $urandom};
                if ((c % 37) == 5) wr(12'h044, $urandom);
                else idle(1);
            end
            rd(12'h040, "R4 rand pend w0"); rd(12'h044, "R4 rand pend w1");
            wr(12'h300, 32'h7);
            cur_in = {$urandom, $urandom}; idle(2);
            rd(12'h040, "R9 rand pend w0"); rd(12'h044, "R9 rand pend w1");
        end
        wr(12'h300, 32'h0);
        cur_in = {$urandom, $urandom}; idle(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule